// File: doc/BRIEF.md
# Logarithmic Shift and Rotate Unit

A purely combinational word shifter that moves a 32-bit operand left or right by 0 to 31 positions. It can also rotate the operand in either direction. An operation code picks the direction and what enters the vacated positions: zeros, copies of the operand's sign bit, or the bits pushed out at the far end. The result is available in the same evaluation as the inputs, with no clock or state.

The datapath is a chain of two-input multiplexer stages, one per shift-amount bit. The stage tied to amount bit k either passes its input or moves it by 2^k places. The stages run from the least significant amount bit upward. A small decoder turns the operation code into a direction and a fill mode, and every stage shares these.

Top module: `barrel_shift_unit`

## Requirements
- R1: With op_i = 3'b000 (logical left), q_o equals d_i shifted left by amt_i, with the amt_i lowest bits zero.
- R2: With op_i = 3'b001 (logical right), q_o equals d_i shifted right by amt_i, with the amt_i highest bits zero.
- R3: With op_i = 3'b010 (arithmetic right), q_o equals d_i shifted right by amt_i, with the amt_i highest bits equal to d_i[31].
- R4: With op_i = 3'b011 (rotate left), bit i of q_o equals bit (i - amt_i) mod 32 of d_i, so no bit is lost.
- R5: With op_i = 3'b100 (rotate right), bit i of q_o equals bit (i + amt_i) mod 32 of d_i, so no bit is lost.
- R6: With amt_i = 0, q_o equals d_i for every op_i value.
- R7: For op_i codes 3'b101, 3'b110 and 3'b111, q_o equals d_i whatever amt_i is.
- R8: The output is combinational: q_o follows d_i, amt_i and op_i with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_i | input | 32 | Operand to be shifted or rotated |
| amt_i | input | 5 | Shift or rotate distance, 0 to 31 |
| op_i | input | 3 | Operation code (see R1 to R7) |
| q_o | output | 32 | Shifted or rotated result |

## Verification
The bench builds the unit with its default 32-bit width and 5-bit amount. At that width, every operation code, including the three unused ones, can be crossed with every shift distance from 0 to 31. Each operand comes from a mix of random words and fixed patterns: sign bit set alone, all ones, a single low one, and alternating bits. This puts the sign-fill and wrap-around boundaries at the largest distances within reach. Each result is compared against a plain arithmetic shift or rotate formula evaluated in the bench, in the same evaluation window as the inputs are applied.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_SLL  = 3'b000,
    OP_SRL  = 3'b001,
    OP_SRA  = 3'b010,
    OP_ROL  = 3'b011,
    OP_ROR  = 3'b100
  } shf_op_e;

  typedef enum logic [1:0] {
    FILL_PASS = 2'b00,
    FILL_ZERO = 2'b01,
    FILL_SIGN = 2'b10,
    FILL_WRAP = 2'b11
  } shf_fill_e;
endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
(
  input  logic [2:0] op_i,
  output logic       left_o,
  output shf_fill_e  fill_o
);
  always_comb begin
    left_o = 1'b0;
    fill_o = FILL_PASS;
    unique case (op_i)
      OP_SLL:  begin left_o = 1'b1; fill_o = FILL_ZERO; end
      OP_SRL:  begin left_o = 1'b0; fill_o = FILL_ZERO; end
      OP_SRA:  begin left_o = 1'b0; fill_o = FILL_SIGN; end
      OP_ROL:  begin left_o = 1'b1; fill_o = FILL_WRAP; end
      OP_ROR:  begin left_o = 1'b0; fill_o = FILL_WRAP; end
      default: begin left_o = 1'b0; fill_o = FILL_PASS; end
    endcase
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage
  import shf_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SHIFT = 1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic             en_i,
  input  logic             left_i,
  input  shf_fill_e        fill_i,
  input  logic             sign_i,
  output logic [WIDTH-1:0] y_o
);
  logic [SHIFT-1:0] fill_l, fill_r;
  logic [WIDTH-1:0] moved_l, moved_r;

  always_comb begin
    unique case (fill_i)
      FILL_WRAP: begin
        fill_l = x_i[WIDTH-1:WIDTH-SHIFT];
        fill_r = x_i[SHIFT-1:0];
      end
      FILL_SIGN: begin
        fill_l = '0;
        fill_r = {SHIFT{sign_i}};
      end
      default: begin
        fill_l = '0;
        fill_r = '0;
      end
    endcase
  end

  assign moved_l = {x_i[WIDTH-SHIFT-1:0], fill_l};
  assign moved_r = {fill_r, x_i[WIDTH-1:SHIFT]};

  // pass when stage bit clear or op is a no-op code
  assign y_o = (en_i && fill_i != FILL_PASS) ? (left_i ? moved_l : moved_r) : x_i;
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shf_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic [AW-1:0]    amt_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] q_o
);
  logic      left;
  shf_fill_e fill;
  logic [WIDTH-1:0] stage_q [AW+1];

  shf_ctrl i_ctrl (
    .op_i   (op_i),
    .left_o (left),
    .fill_o (fill)
  );

  assign stage_q[0] = d_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    shf_stage #(
      .WIDTH (WIDTH),
      .SHIFT (1 << k)
    ) i_stage (
      .x_i    (stage_q[k]),
      .en_i   (amt_i[k]),
      .left_i (left),
      .fill_i (fill),
      .sign_i (d_i[WIDTH-1]),
      .y_o    (stage_q[k+1])
    );
  end

  assign q_o = stage_q[AW];
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] d_i,
  input logic [AW-1:0]    amt_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] low_mask, high_mask;
  assign low_mask  = ~({WIDTH{1'b1}} << amt_i);
  assign high_mask = ~({WIDTH{1'b1}} >> amt_i);

  always_comb begin
    AST_SLL_LOW_ZERO: assert (!(op_i == 3'b000) || (q_o & low_mask) == '0); // R1
    AST_SRL_HIGH_ZERO: assert (!(op_i == 3'b001) || (q_o & high_mask) == '0); // R2
    AST_SRA_SIGN_FILL: assert (!(op_i == 3'b010) ||
      (q_o & high_mask) == (d_i[WIDTH-1] ? high_mask : '0)); // R3
    AST_ROL_KEEPS_BITS: assert (!(op_i == 3'b011) || $countones(q_o) == $countones(d_i)); // R4
    AST_ROR_KEEPS_BITS: assert (!(op_i == 3'b100) || $countones(q_o) == $countones(d_i)); // R5
    AST_ZERO_AMT_IDENT: assert (amt_i != '0 || q_o == d_i); // R6
    AST_SPARE_OP_PASS: assert (op_i < 3'b101 || q_o == d_i); // R7
  end
endmodule

bind barrel_shift_unit shf_checker #(.WIDTH(WIDTH)) i_shf_checker (
  .d_i   (d_i),
  .amt_i (amt_i),
  .op_i  (op_i),
  .q_o   (q_o)
);

// File: tb/test_barrel_shift_unit.sv
module test_barrel_shift_unit;
  localparam int unsigned W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  d;
  logic [4:0]    amt;
  logic [2:0]    op;
  logic [W-1:0]  q;
  int            checks = 0;
  int            errors = 0;
  int unsigned   cycles = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  barrel_shift_unit i_barrel_shift_unit (
    .d_i   (d),
    .amt_i (amt),
    .op_i  (op),
    .q_o   (q)
  );

  function automatic logic [W-1:0] model(input logic [2:0] o, input logic [W-1:0] x,
                                         input int unsigned s);
    logic [63:0] dbl;
    dbl = {x, x};
    case (o)
      3'd0: return x << s;
      3'd1: return x >> s;
      3'd2: return W'($signed(x) >>> s);
      3'd3: return dbl[63-s -: 32];
      3'd4: return dbl[s +: 32];
      default: return x;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o, input int unsigned s);
    if (s == 0) return "R6";
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d amt=%0d d=%h: got %h expected %h", req, op, amt, d, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [6];
    d = '0; amt = '0; op = '0;
    repeat (3) @(negedge clk);
    #5 check("R8", q, '0); // reset-time state: zero in, zero out
    rst_n = 1'b1;

    // R8: output follows inputs within the same cycle
    @(negedge clk);
    d = 32'h0000_00F0; amt = 5'd4; op = 3'd0;
    #1 check("R8", q, 32'h0000_0F00);
    d = 32'h0000_00F0; amt = 5'd4; op = 3'd1;
    #1 check("R8", q, 32'h0000_000F);

    // R3 vs R2: sign fill only differs with MSB set
    @(negedge clk);
    d = 32'h8000_0000; amt = 5'd31; op = 3'd2;
    #5 check("R3", q, 32'hFFFF_FFFF);
    op = 3'd1;
    #5 check("R2", q, 32'h0000_0001);
    // R4 / R5 wrap at maximum distance
    d = 32'h0000_0001; op = 3'd4;
    #5 check("R5", q, 32'h0000_0002);
    op = 3'd3;
    #5 check("R4", q, 32'h8000_0000);

    for (int o = 0; o < 8; o++) begin
      pats[0] = 32'h8000_0000;
      pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h0000_0001;
      pats[3] = 32'hA5A5_5A5A;
      pats[4] = $urandom() | 32'h8000_0000;
      pats[5] = $urandom() & 32'h7FFF_FFFF;
      for (int s = 0; s < 32; s++) begin
        for (int p = 0; p < 6; p++) begin
          @(negedge clk);
          op = 3'(o); amt = 5'(s); d = pats[p];
          #5 check(req_of(3'(o), s), q, model(3'(o), pats[p], s));
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule